// File: doc/BRIEF.md
# Page Write-Lock Guard

This block sits in front of a user memory zone and decides, one request at a time, whether a write may land and what value is stored. The zone is split into pages of eight bytes. When write-lock mode is on for the zone, the first byte of every page acts as a bitmask for that page. A 1 in bit n leaves byte n of the page writable. A 0 in bit n protects that byte. Bit 0 covers the mask byte itself, so clearing it freezes the mask for good.

The surrounding logic presents the write address, the data, the zone's write-lock enable, and the current contents of the addressed page's first byte. One cycle later the block reports whether the write is permitted and which value the memory should store. A permitted write to the mask byte can only clear bits, because the stored value is the old mask ANDed with the new data. With write-lock mode off, every write passes through unchanged, and the first byte of a page is ordinary data.

Internally a three-state machine holds the outcome of the latest request. State `WL_IDLE` means no result is pending. State `WL_COMMIT` means the last request was permitted. State `WL_DISCARD` means the last request was rejected. On every clock edge a present request moves the machine to `WL_COMMIT` or `WL_DISCARD`, according to the lock decision. With no request present, it returns to `WL_IDLE`.

Top module: `wl_guard`

## Requirements
- R1: After reset, and before any request, `res_valid`, `res_permit` and `res_data` are all 0.
- R2: Each cycle with `req_valid` high yields exactly one cycle of `res_valid` on the next cycle, with `res_addr` equal to the request address. Back-to-back requests give back-to-back results, and a cycle without a request gives `res_valid` low one cycle later.
- R3: With `wl_en` low, every write is permitted and `res_data` equals `req_data` at every offset, offset 0 included. Bits of byte 0 may rise again.
- R4: With `wl_en` high, the offset is `req_addr[2:0]` and the page's lock byte is `lock_byte`. A write at a non-zero offset n is permitted exactly when bit n of `lock_byte` is 1, and a permitted write stores `req_data` unchanged.
- R5: With `wl_en` high and bit 0 of `lock_byte` equal to 1, a write at offset 0 is permitted and stores `lock_byte & req_data`, so no bit rises from 0 to 1.
- R6: With `wl_en` high and bit 0 of `lock_byte` equal to 0, every write at offset 0 is rejected.
- R7: A rejected write gives `res_valid` high with `res_permit` low and `res_data` equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request present this cycle |
| req_addr | input | ADDR_W | Byte address of the write |
| req_data | input | PAGE_BYTES | Data to write |
| wl_en | input | 1 | Write-lock mode enabled for the zone |
| lock_byte | input | PAGE_BYTES | Current contents of the addressed page's first byte |
| res_valid | output | 1 | Result of the previous cycle's request |
| res_permit | output | 1 | 1 when the write may be committed |
| res_addr | output | ADDR_W | Address belonging to the result |
| res_data | output | PAGE_BYTES | Value to commit, 0 when rejected |

## Verification
Every result is due exactly one clock after its request, because a single register stage lies between the request inputs and the result outputs. The driver applies each request at a falling edge and pushes the expected outcome into a queue. The outcome comes from a behavioural page memory that the bench updates on every permitted write. The monitor samples at the next falling edge, pops the oldest entry whenever `res_valid` is high, and flags any result that arrives with no matching entry. Idle cycles and the final drain check that nothing is left over and that no extra result appears.

// File: rtl/wl_pkg.sv
package wl_pkg;

    // Outcome held for the result cycle
    typedef enum logic [1:0] {
        WL_IDLE    = 2'd0,
        WL_COMMIT  = 2'd1,
        WL_DISCARD = 2'd2
    } wl_state_e;

endpackage

// File: rtl/wl_offset_gate.sv
// Decides whether the addressed byte of a page may be written.
module wl_offset_gate #(
    parameter int PAGE_BYTES = 8,
    localparam int OFF_W = $clog2(PAGE_BYTES)
) (
    input  logic [OFF_W-1:0]      offset,
    input  logic [PAGE_BYTES-1:0] lock_byte,
    input  logic                  wl_en,
    output logic                  allow,
    output logic                  on_mask_slot
);

    logic [PAGE_BYTES-1:0] hit;

    // one select term per byte slot of the page
    for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_slot
        assign hit[i] = (offset == OFF_W'(i)) && lock_byte[i];
    end

    assign on_mask_slot = (offset == '0);
    assign allow        = !wl_en || (|hit);

endmodule

// File: rtl/wl_commit_merge.sv
// Forms the value to store; the mask byte can only lose ones.
module wl_commit_merge #(
    parameter int PAGE_BYTES = 8
) (
    input  logic                  wl_en,
    input  logic                  on_mask_slot,
    input  logic [PAGE_BYTES-1:0] new_val,
    input  logic [PAGE_BYTES-1:0] old_mask,
    output logic [PAGE_BYTES-1:0] merged
);

    logic one_way;
    assign one_way = wl_en && on_mask_slot;

    for (genvar b = 0; b < PAGE_BYTES; b++) begin : g_bit
        assign merged[b] = one_way ? (new_val[b] & old_mask[b]) : new_val[b];
    end

endmodule

// File: rtl/wl_guard.sv
module wl_guard
    import wl_pkg::*;
#(
    parameter int ADDR_W     = 6,
    parameter int PAGE_BYTES = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [PAGE_BYTES-1:0] req_data,
    input  logic                  wl_en,
    input  logic [PAGE_BYTES-1:0] lock_byte,
    output logic                  res_valid,
    output logic                  res_permit,
    output logic [ADDR_W-1:0]     res_addr,
    output logic [PAGE_BYTES-1:0] res_data
);

    localparam int OFF_W = $clog2(PAGE_BYTES);

    wl_state_e             state_q, state_d;
    logic [ADDR_W-1:0]     addr_q;
    logic [PAGE_BYTES-1:0] data_q;
    logic                  allow;
    logic                  on_mask_slot;
    logic [PAGE_BYTES-1:0] merged;

    wl_offset_gate #(.PAGE_BYTES(PAGE_BYTES)) u_gate (
        .offset       (req_addr[OFF_W-1:0]),
        .lock_byte    (lock_byte),
        .wl_en        (wl_en),
        .allow        (allow),
        .on_mask_slot (on_mask_slot)
    );

    wl_commit_merge #(.PAGE_BYTES(PAGE_BYTES)) u_merge (
        .wl_en        (wl_en),
        .on_mask_slot (on_mask_slot),
        .new_val      (req_data),
        .old_mask     (lock_byte),
        .merged       (merged)
    );

    // next-state: every request decides COMMIT or DISCARD
    always_comb begin
        state_d = WL_IDLE;
        if (req_valid) begin
            state_d = allow ? WL_COMMIT : WL_DISCARD;
        end
    end

    // state register with captured request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WL_IDLE;
            addr_q  <= '0;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            if (req_valid) begin
                addr_q <= req_addr;
                data_q <= merged;
            end
        end
    end

    // outputs decoded from the state
    always_comb begin
        res_addr = addr_q;
        unique case (state_q)
            WL_COMMIT: begin
                res_valid  = 1'b1;
                res_permit = 1'b1;
                res_data   = data_q;
            end
            WL_DISCARD: begin
                res_valid  = 1'b1;
                res_permit = 1'b0;
                res_data   = '0;
            end
            default: begin
                res_valid  = 1'b0;
                res_permit = 1'b0;
                res_data   = '0;
            end
        endcase
    end

endmodule

// File: rtl/wl_guard_chk.sv
module wl_guard_chk #(
    parameter int ADDR_W     = 6,
    parameter int PAGE_BYTES = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  req_valid,
    input logic [ADDR_W-1:0]     req_addr,
    input logic [PAGE_BYTES-1:0] req_data,
    input logic                  wl_en,
    input logic [PAGE_BYTES-1:0] lock_byte,
    input logic                  res_valid,
    input logic                  res_permit,
    input logic [ADDR_W-1:0]     res_addr,
    input logic [PAGE_BYTES-1:0] res_data
);

    localparam int OFF_W = $clog2(PAGE_BYTES);
    localparam logic [PAGE_BYTES-1:0] ZERO = '0;

    logic [OFF_W-1:0] off;
    logic             lock_bit;
    assign off      = req_addr[OFF_W-1:0];
    assign lock_bit = lock_byte[off];

    AST_RESULT_DUE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (res_valid && res_addr == $past(req_addr))); // R2

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !res_valid); // R2

    AST_OPEN_ZONE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !wl_en) |=> (res_permit && res_data == $past(req_data))); // R3

    AST_LOCKED_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && wl_en && !lock_bit) |=> !res_permit); // R4

    AST_MASK_ONE_WAY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && wl_en && off == '0) |=> ((res_data & ~$past(lock_byte)) == ZERO)); // R5

    AST_SELF_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && wl_en && off == '0 && !lock_byte[0]) |=> (res_valid && !res_permit)); // R6

    AST_DISCARD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_permit) |-> (res_data == ZERO)); // R7

    AST_PERMIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        res_permit |-> res_valid); // R7

endmodule

bind wl_guard wl_guard_chk #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .req_data   (req_data),
    .wl_en      (wl_en),
    .lock_byte  (lock_byte),
    .res_valid  (res_valid),
    .res_permit (res_permit),
    .res_addr   (res_addr),
    .res_data   (res_data)
);

// File: tb/sim_wl_guard.sv
`timescale 1ns/1ps
module sim_wl_guard;

    localparam int ADDR_W = 6;
    localparam int PB     = 8;
    localparam int DEPTH  = 1 << ADDR_W;

    typedef struct {
        logic              permit;
        logic [PB-1:0]     data;
        logic [ADDR_W-1:0] addr;
        string             tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [PB-1:0]     req_data = '0;
    logic              wl_en = 1'b0;
    logic [PB-1:0]     lock_byte = '0;
    logic              res_valid, res_permit;
    logic [ADDR_W-1:0] res_addr;
    logic [PB-1:0]     res_data;

    int   n_checks = 0;
    int   n_fail   = 0;
    exp_t sb_q[$];
    logic [PB-1:0] mem [DEPTH];

    always #4 clk = ~clk;

    wl_guard #(.ADDR_W(ADDR_W), .PAGE_BYTES(PB)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_data(req_data), .wl_en(wl_en), .lock_byte(lock_byte),
        .res_valid(res_valid), .res_permit(res_permit), .res_addr(res_addr),
        .res_data(res_data)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // driver: apply one write request and queue its expected outcome
    task automatic send(input logic [ADDR_W-1:0] a, input logic [PB-1:0] d,
                        input logic wl, input string tag);
        exp_t e;
        logic [PB-1:0] lk;
        logic [2:0]    off;
        @(negedge clk);
        off = a[2:0];
        lk  = mem[{a[ADDR_W-1:3], 3'b000}];
        req_valid = 1'b1; req_addr = a; req_data = d; wl_en = wl; lock_byte = lk;
        e.addr = a; e.tag = tag;
        if (!wl) begin
            e.permit = 1'b1; e.data = d;
        end else if (!lk[off]) begin
            e.permit = 1'b0; e.data = '0;
        end else begin
            e.permit = 1'b1; e.data = (off == 3'd0) ? (d & lk) : d;
        end
        if (e.permit) mem[a] = e.data;
        sb_q.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // monitor: compare each result one cycle after its request
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R2", "unexpected result", 1, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(res_addr == e.addr, e.tag, "addr", int'(res_addr), int'(e.addr));
                check(res_permit == e.permit, e.tag, "permit", int'(res_permit), int'(e.permit));
                check(res_data == e.data, e.tag, "data", int'(res_data), int'(e.data));
            end
        end
    end

    function automatic string tag_for(logic [ADDR_W-1:0] a, logic wl);
        logic [PB-1:0] lk;
        lk = mem[{a[ADDR_W-1:3], 3'b000}];
        if (!wl) return "R3";
        if (a[2:0] == 3'd0) return lk[0] ? "R5" : "R6/R7";
        return lk[a[2:0]] ? "R4" : "R4/R7";
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        check(1'b0, "WDOG", "timeout", 0, 1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        logic [15:0] lfsr;
        for (int i = 0; i < DEPTH; i++) mem[i] = 8'hFF;
        repeat (3) @(negedge clk);
        check(res_valid == 1'b0, "R1", "res_valid in reset", int'(res_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(res_valid == 1'b0 && res_permit == 1'b0, "R1", "valid/permit after reset",
              int'({res_valid, res_permit}), 0);
        check(res_data == '0, "R1", "data after reset", int'(res_data), 0);

        // R3: lock mode off, byte 0 is ordinary and may rise again
        send(6'd3, 8'h5A, 1'b0, "R3");
        send(6'd8, 8'h00, 1'b0, "R3");
        send(6'd8, 8'hFF, 1'b0, "R3");
        send(6'd9, 8'h11, 1'b0, "R3");
        idle();
        idle();
        check(res_valid == 1'b0, "R2", "no result after idle", int'(res_valid), 0);

        // R5 then R4: mask 0xD9 protects offsets 1, 2 and 5
        send(6'd0, 8'hD9, 1'b1, "R5");
        send(6'd1, 8'h33, 1'b1, "R4/R7");
        send(6'd3, 8'h44, 1'b1, "R4");
        send(6'd2, 8'h55, 1'b1, "R4/R7");
        send(6'd5, 8'h66, 1'b1, "R4/R7");
        send(6'd7, 8'h77, 1'b1, "R4");
        send(6'd0, 8'hFF, 1'b1, "R5");
        // R6: clear bit 0, mask then frozen
        send(6'd0, 8'hD8, 1'b1, "R5");
        send(6'd0, 8'hFF, 1'b1, "R6/R7");
        send(6'd0, 8'h00, 1'b1, "R6/R7");
        // R3: lock mode off overrides a frozen mask
        send(6'd0, 8'hF0, 1'b0, "R3");
        // R2: back-to-back stream over page 1
        for (int k = 9; k < 16; k++) send(ADDR_W'(k), 8'(k * 3), 1'b1, "R2/R4");
        idle();

        lfsr = 16'hACE1;
        for (int k = 0; k < 300; k++) begin
            logic [ADDR_W-1:0] a;
            logic wl;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            a  = lfsr[5:0];
            if (lfsr[8:7] == 2'b00) a[2:0] = 3'd0;
            wl = (lfsr[11:9] != 3'd0);
            if (lfsr[14:12] == 3'd7) idle();
            else send(a, lfsr[15:8] ^ lfsr[7:0], wl, tag_for(a, wl));
        end
        idle();
        idle();
        idle();
        check(sb_q.size() == 0, "R2", "results outstanding", sb_q.size(), 0);
        check(res_valid == 1'b0, "R2", "trailing result", int'(res_valid), 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule